// File: doc/BRIEF.md
# Coprocessor Bus-Cycle Tracker and Ready Generator

This block is the synchronous front end that lets a numeric coprocessor share a host processor's bus. It watches every bus cycle from the clock in which the address strobe is sampled. In that first period it decides whether the cycle is addressed to the coprocessor. For a cycle that is, it also decides what kind of transfer the cycle carries. Each selected cycle sends the core one single-clock strobe of four kinds, and write strobes carry the data word. The block then ends the cycle itself through an active-low ready output, after a fixed number of clocks that depends on the direction.

Writes of the long kind (environment load, state restore) are exempt from the fixed timing. For these the ready output waits for a completion pulse from the core. Selected or not, every cycle is followed until the shared ready line is sampled low, and no new cycle is accepted before that. A chip-enable input gates the enables of the status-type outputs and of the data bus driver.

The controller is a state machine with seven states:
- IDLE waits for a cycle start.
- WR_RDY drives ready for an ordinary selected write.
- RD_WAIT inserts the extra wait clock of a selected read.
- RD_RDY drives ready for a read.
- EX_WAIT waits for the core on an exempt write.
- EX_RDY drives ready after the core completes.
- TRACK follows an unselected or stretched cycle until the shared ready is sampled.

From IDLE, a start goes to WR_RDY, RD_WAIT, EX_WAIT or TRACK, according to the select, direction and exempt inputs. RD_WAIT moves to RD_RDY once its count is reached, and EX_WAIT moves to EX_RDY on the completion pulse. Each of the three ready states goes to IDLE if the shared ready is sampled low and to TRACK otherwise. Every state returns to IDLE whenever the shared ready is sampled low.

Top module: `cop_bus_tracker`

## Requirements
- R1: A cycle starts when `ads_n` is sampled low while the tracker is idle; a low `ads_n` sampled during an unfinished cycle is ignored (no strobe, no ready).
- R2: A cycle is selected only if `chip_en`=1, `sel1_n`=0 and `sel2`=1 are all sampled in its first period; any other combination leaves it unselected.
- R3: Each selected cycle raises exactly one strobe, high for one clock in the clock after the first period. The kind is set by the first-period inputs: `wr`=1,`cmd_n`=0 gives `stb_opw`; `wr`=1,`cmd_n`=1 gives `stb_dw`; `wr`=0,`cmd_n`=0 gives `stb_sr`; `wr`=0,`cmd_n`=1 gives `stb_dr`. On a write, `stb_data` holds the `data_in` word sampled in the first period.
- R4: For a selected write with `xfer_long`=0, `rdyo_n` is low for exactly the second clock of the cycle, so the cycle ends after two clocks.
- R5: For a selected read, `rdyo_n` is high in the second clock and low in the third, so the cycle ends after three clocks.
- R6: For a selected write with `xfer_long`=1 in the first period, `rdyo_n` stays high until `core_done` is sampled high; it is low for the one clock that follows.
- R7: `rdyo_n` is never low during a cycle that is not selected.
- R8: After its ready clock, or throughout an unselected cycle, the tracker stays in the cycle until `rdy_n` is sampled low, and only then returns to idle.
- R9: `oe_ctl` is registered from `chip_en`: it is low in the clock after `chip_en` is sampled low, and high in the clock after it is sampled high.
- R10: `oe_data` is high from the clock after the first period of a selected read until that cycle ends, and only while `chip_en` is high.
- R11: The synchronous reset `rst` returns the tracker to idle and forces `rdyo_n` high, all strobes low and both enables low, even in the middle of a cycle.
- R12: `xfer_long` has no effect on reads; a selected read keeps the R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Address strobe, low in the first period of a cycle |
| wr | input | 1 | Direction, 1 = write, sampled in the first period |
| sel1_n | input | 1 | Select 1, active low |
| sel2 | input | 1 | Select 2, active high |
| chip_en | input | 1 | Chip enable, active high |
| cmd_n | input | 1 | Command, low = opcode / control-status, high = data |
| rdy_n | input | 1 | Shared bus ready, active low |
| xfer_long | input | 1 | Core flag: the current write is an exempt long transfer |
| core_done | input | 1 | Core completion pulse for an exempt transfer |
| data_in | input | DW | Write data from the bus |
| rdyo_n | output | 1 | Ready output, active low |
| stb_opw | output | 1 | Opcode-write strobe |
| stb_dw | output | 1 | Data-write strobe |
| stb_sr | output | 1 | Control/status-read strobe |
| stb_dr | output | 1 | Data-read strobe |
| stb_data | output | DW | Write word captured with a write strobe |
| oe_ctl | output | 1 | Enable for the busy, operand-request, error and ready drivers |
| oe_data | output | 1 | Enable for the data bus driver |

## Verification
The assertions assume a bus of the non-pipelined kind. `ads_n` is low for a single clock per cycle. The shared `rdy_n` is sampled low at most once per cycle, and `core_done` only pulses while an exempt write is pending. The bench keeps to these conditions by deriving `rdy_n` from `rdyo_n` and a bench-owned extra ready. It also pulses `core_done` for one clock only on exempt writes. The single deliberate exception is a second `ads_n` issued inside a stretched cycle, which is there to show that it is ignored.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_RDY,
        ST_RD_WAIT,
        ST_RD_RDY,
        ST_EX_WAIT,
        ST_EX_RDY,
        ST_TRACK
    } cbt_state_e;

    typedef enum logic [1:0] {
        K_OPW,
        K_DW,
        K_SR,
        K_DR
    } cbt_kind_e;

endpackage

// File: rtl/cbt_decode.sv
module cbt_decode
    import cbt_pkg::*;
(
    input  logic      ads_n,
    input  logic      chip_en,
    input  logic      sel1_n,
    input  logic      sel2,
    input  logic      wr,
    input  logic      cmd_n,
    output logic      start,
    output logic      hit,
    output cbt_kind_e kind
);

    always_comb begin
        start = !ads_n;
        hit   = chip_en && !sel1_n && sel2;
        unique case ({wr, cmd_n})
            2'b10:   kind = K_OPW;
            2'b11:   kind = K_DW;
            2'b00:   kind = K_SR;
            default: kind = K_DR;
        endcase
    end

endmodule

// File: rtl/cbt_fsm.sv
module cbt_fsm
    import cbt_pkg::*;
#(
    parameter int RD_EXTRA = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hit,
    input  logic wr,
    input  logic xfer_long,
    input  logic core_done,
    input  logic rdy_n,
    output logic accept,
    output logic rd_active,
    output logic rdyo_n
);

    localparam int CW = (RD_EXTRA > 1) ? $clog2(RD_EXTRA) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RD_EXTRA - 1);

    cbt_state_e      state, nxt;
    logic [CW-1:0]   cnt;
    logic            sel_q, rd_q;

    assign accept = (state == ST_IDLE) && start && hit;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!hit)          nxt = ST_TRACK;
                    else if (!wr)      nxt = ST_RD_WAIT;
                    else if (xfer_long) nxt = ST_EX_WAIT;
                    else               nxt = ST_WR_RDY;
                end
            end
            ST_RD_WAIT: begin
                if (!rdy_n)               nxt = ST_IDLE;
                else if (cnt == CNT_LAST) nxt = ST_RD_RDY;
            end
            ST_EX_WAIT: begin
                if (!rdy_n)         nxt = ST_IDLE;
                else if (core_done) nxt = ST_EX_RDY;
            end
            ST_WR_RDY, ST_RD_RDY, ST_EX_RDY: begin
                nxt = rdy_n ? ST_TRACK : ST_IDLE;
            end
            ST_TRACK: begin
                if (!rdy_n) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sel_q <= 1'b0;
            rd_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RD_WAIT) cnt <= cnt + 1'b1;
            else                     cnt <= '0;
            if (accept) begin
                sel_q <= 1'b1;
                rd_q  <= !wr;
            end else if (nxt == ST_IDLE) begin
                sel_q <= 1'b0;
                rd_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        rdyo_n    = !((state == ST_WR_RDY) || (state == ST_RD_RDY) || (state == ST_EX_RDY));
        rd_active = rd_q;
    end

    // R4: an ordinary selected write is readied in its second clock
    a_r4_write_two: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && hit && wr && !xfer_long) |=> !rdyo_n);

    // R5 / R12: a selected read never readies in its second clock
    a_r5_read_gap: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && hit && !wr) |=> rdyo_n);

    // R6: an exempt write waits for the core
    a_r6_ex_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EX_WAIT && !core_done && rdy_n) |=> rdyo_n);

    // R7: ready only inside a selected cycle
    a_r7_sel_only: assert property (@(posedge clk) disable iff (rst)
        !rdyo_n |-> sel_q);

    // R8: no return to idle without the shared ready
    a_r8_track_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && rdy_n && !(state == ST_EX_WAIT && core_done))
            |=> (state != ST_IDLE));

endmodule

// File: rtl/cbt_strobe.sv
module cbt_strobe
    import cbt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  cbt_kind_e     kind,
    input  logic [DW-1:0] data_in,
    output logic          stb_opw,
    output logic          stb_dw,
    output logic          stb_sr,
    output logic          stb_dr,
    output logic [DW-1:0] stb_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_opw  <= 1'b0;
            stb_dw   <= 1'b0;
            stb_sr   <= 1'b0;
            stb_dr   <= 1'b0;
            stb_data <= '0;
        end else begin
            stb_opw <= fire && (kind == K_OPW);
            stb_dw  <= fire && (kind == K_DW);
            stb_sr  <= fire && (kind == K_SR);
            stb_dr  <= fire && (kind == K_DR);
            if (fire && (kind == K_OPW || kind == K_DW))
                stb_data <= data_in;
        end
    end

    // R3: one strobe at a time
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_opw, stb_dw, stb_sr, stb_dr}));

    // R3: a strobe lasts one clock
    a_r3_pulse: assert property (@(posedge clk) disable iff (rst)
        (stb_opw || stb_dw || stb_sr || stb_dr) |=> !(stb_opw || stb_dw || stb_sr || stb_dr));

endmodule

// File: rtl/cbt_oe.sv
module cbt_oe (
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic rd_active,
    output logic oe_ctl,
    output logic oe_data
);

    always_ff @(posedge clk) begin
        if (rst) oe_ctl <= 1'b0;
        else     oe_ctl <= chip_en;
    end

    assign oe_data = rd_active && chip_en;

    // R9: chip enable low turns the status-type enables off
    a_r9_ce_off: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !oe_ctl);

    // R10: the data driver is only on while enabled
    a_r10_data_ce: assert property (@(posedge clk) disable iff (rst)
        oe_data |-> chip_en);

endmodule

// File: rtl/cop_bus_tracker.sv
module cop_bus_tracker
    import cbt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int RD_EXTRA = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ads_n,
    input  logic          wr,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          chip_en,
    input  logic          cmd_n,
    input  logic          rdy_n,
    input  logic          xfer_long,
    input  logic          core_done,
    input  logic [DW-1:0] data_in,
    output logic          rdyo_n,
    output logic          stb_opw,
    output logic          stb_dw,
    output logic          stb_sr,
    output logic          stb_dr,
    output logic [DW-1:0] stb_data,
    output logic          oe_ctl,
    output logic          oe_data
);

    logic      start, hit, accept, rd_active;
    cbt_kind_e kind;

    cbt_decode u_decode (
        .ads_n   (ads_n),
        .chip_en (chip_en),
        .sel1_n  (sel1_n),
        .sel2    (sel2),
        .wr      (wr),
        .cmd_n   (cmd_n),
        .start   (start),
        .hit     (hit),
        .kind    (kind)
    );

    cbt_fsm #(.RD_EXTRA(RD_EXTRA)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .hit       (hit),
        .wr        (wr),
        .xfer_long (xfer_long),
        .core_done (core_done),
        .rdy_n     (rdy_n),
        .accept    (accept),
        .rd_active (rd_active),
        .rdyo_n    (rdyo_n)
    );

    cbt_strobe #(.DW(DW)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .fire     (accept),
        .kind     (kind),
        .data_in  (data_in),
        .stb_opw  (stb_opw),
        .stb_dw   (stb_dw),
        .stb_sr   (stb_sr),
        .stb_dr   (stb_dr),
        .stb_data (stb_data)
    );

    cbt_oe u_oe (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .rd_active (rd_active),
        .oe_ctl    (oe_ctl),
        .oe_data   (oe_data)
    );

endmodule

// File: tb/cop_bus_tracker_bench.sv
module cop_bus_tracker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ads_n = 1'b1, wr = 1'b0, sel1_n = 1'b1, sel2 = 1'b0;
    logic        chip_en = 1'b1, cmd_n = 1'b1, xfer_long = 1'b0, core_done = 1'b0;
    logic        ext_rdy_n = 1'b1, mask_rdy = 1'b0;
    logic [31:0] data_in = '0;
    logic        rdy_n, rdyo_n, stb_opw, stb_dw, stb_sr, stb_dr, oe_ctl, oe_data;
    logic [31:0] stb_data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign rdy_n = mask_rdy ? ext_rdy_n : (rdyo_n & ext_rdy_n);

    cop_bus_tracker u_cop_bus_tracker (
        .clk(clk), .rst(rst), .ads_n(ads_n), .wr(wr), .sel1_n(sel1_n), .sel2(sel2),
        .chip_en(chip_en), .cmd_n(cmd_n), .rdy_n(rdy_n), .xfer_long(xfer_long),
        .core_done(core_done), .data_in(data_in), .rdyo_n(rdyo_n),
        .stb_opw(stb_opw), .stb_dw(stb_dw), .stb_sr(stb_sr), .stb_dr(stb_dr),
        .stb_data(stb_data), .oe_ctl(oe_ctl), .oe_data(oe_data)
    );

    typedef struct packed {
        logic        wr;
        logic        s1n;
        logic        s2;
        logic        ce;
        logic        cmdn;
        logic        ex;
        logic [31:0] d;
        logic [2:0]  code;  // 0 none, 1 opw, 2 dw, 3 sr, 4 dr
        logic [2:0]  lat;   // clock of the cycle minus one when rdyo_n is low, 0 never
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, 3'd1, 3'd1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h1234_5678, 3'd2, 3'd1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         3'd3, 3'd2},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,         3'd4, 3'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF, 3'd2, 3'd4},
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0005, 3'd0, 3'd0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,         3'd0, 3'd0},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0007, 3'd0, 3'd0},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0,         3'd4, 3'd2},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0BAD_F00D, 3'd1, 3'd4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] stb_code();
        if (stb_opw) return 3'd1;
        if (stb_dw)  return 3'd2;
        if (stb_sr)  return 3'd3;
        if (stb_dr)  return 3'd4;
        return 3'd0;
    endfunction

    task automatic drive_start(input vec_t v);
        @(negedge clk);
        ads_n = 1'b0; wr = v.wr; sel1_n = v.s1n; sel2 = v.s2;
        chip_en = v.ce; cmd_n = v.cmdn; xfer_long = v.ex; data_in = v.d;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic [2:0] lat = 3'd0;
        bit exw = v.ex && v.wr && (v.code != 3'd0);
        drive_start(v);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 1) begin
                ads_n = 1'b1;
                // R3: strobe kind in the clock after the first period
                chk(stb_code() == v.code, {tag, " R3 strobe"}, 32'(stb_code()), 32'(v.code));
                if (v.code == 3'd1 || v.code == 3'd2)
                    chk(stb_data == v.d, {tag, " R3 data"}, stb_data, v.d);
                // R10: data enable on selected reads
                chk(oe_data == (v.code >= 3'd3), {tag, " R10 oe_data"}, 32'(oe_data), 32'(v.code >= 3'd3));
            end
            if (k == 2)
                chk(stb_code() == 3'd0, {tag, " R3 one clock"}, 32'(stb_code()), 32'd0);
            if (!rdyo_n && lat == 3'd0) lat = 3'(k);
            if (exw && k == 3) core_done = 1'b1;
            if (k == 4) core_done = 1'b0;
        end
        // R4 R5 R6 R7 R12: ready timing
        chk(lat == v.lat, {tag, " R4/R5/R6/R7 ready clock"}, 32'(lat), 32'(v.lat));
        if (v.lat == 3'd0) begin
            ext_rdy_n = 1'b0;
            @(negedge clk);
            ext_rdy_n = 1'b1;
        end
        chip_en = 1'b1; xfer_long = 1'b0; sel1_n = 1'b1; sel2 = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rdyo_n == 1'b1, "R11 rdyo_n", 32'(rdyo_n), 32'd1);
        chk(stb_code() == 3'd0, "R11 strobes", 32'(stb_code()), 32'd0);
        chk(oe_ctl == 1'b0 && oe_data == 1'b0, "R11 enables", 32'({oe_ctl, oe_data}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(oe_ctl == 1'b1, "R9 oe_ctl on", 32'(oe_ctl), 32'd1);

        for (int i = 0; i < NV; i++) run_vec(VT[i], $sformatf("vec%0d R1 R2", i));

        // R9: chip enable off, then on
        @(negedge clk); chip_en = 1'b0;
        @(negedge clk);
        chk(oe_ctl == 1'b0, "R9 oe_ctl off", 32'(oe_ctl), 32'd0);
        chip_en = 1'b1;
        @(negedge clk);
        chk(oe_ctl == 1'b1, "R9 oe_ctl back", 32'(oe_ctl), 32'd1);

        // R8 and R1: stretched selected write, second start ignored
        mask_rdy = 1'b1;
        drive_start('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h5, 3'd2, 3'd1});
        @(negedge clk); ads_n = 1'b1;
        chk(rdyo_n == 1'b0, "R4 stretched write ready", 32'(rdyo_n), 32'd0);
        @(negedge clk);
        chk(rdyo_n == 1'b1, "R8 ready single clock", 32'(rdyo_n), 32'd1);
        ads_n = 1'b0; wr = 1'b0; cmd_n = 1'b0;
        @(negedge clk); ads_n = 1'b1;
        chk(stb_code() == 3'd0, "R1 start ignored in cycle", 32'(stb_code()), 32'd0);
        chk(oe_data == 1'b0, "R1 no read enable", 32'(oe_data), 32'd0);
        repeat (2) begin
            @(negedge clk);
            chk(rdyo_n == 1'b1, "R8 held in cycle", 32'(rdyo_n), 32'd1);
        end
        ext_rdy_n = 1'b0;
        @(negedge clk); ext_rdy_n = 1'b1;

        // R10: stretched read keeps the data enable, chip enable cuts it
        drive_start('{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 3'd4, 3'd2});
        @(negedge clk); ads_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(oe_data == 1'b1, "R10 held during stretch", 32'(oe_data), 32'd1);
        chip_en = 1'b0; #1;
        chk(oe_data == 1'b0, "R10 cut by chip enable", 32'(oe_data), 32'd0);
        chip_en = 1'b1;
        ext_rdy_n = 1'b0;
        @(negedge clk); ext_rdy_n = 1'b1;
        @(negedge clk);
        chk(oe_data == 1'b0, "R10 off after end", 32'(oe_data), 32'd0);
        mask_rdy = 1'b0;

        // R8: a normal cycle works after the stretched ones
        run_vec(VT[2], "after-stretch R8");

        // R11: reset in the middle of an unselected cycle
        drive_start(VT[5]);
        @(negedge clk); ads_n = 1'b1; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(oe_ctl == 1'b0, "R11 mid-cycle enables", 32'(oe_ctl), 32'd0);
        run_vec(VT[0], "post-reset R11");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule